// File: doc/BRIEF.md
# ADC Integration Cycle Controller

This block paces the integration windows of a two-channel light-sensing converter. A control register supplies a power bit and an ADC enable bit, and an 8-bit timing value selects how integration is paced. An external interval tick marks each 2.7 ms unit of integration time. When the timing value is nonzero, it is the two's complement of the number of intervals in one integration cycle, so FFh gives one interval and 01h gives 255. When the timing value is zero, the block is in manual mode. In manual mode, integration runs from a start command to a stop command, and the block keeps a count of the intervals that elapsed.

The block drives three signals: `integrating` for the analog front end, a one-clock `cycleDone` strobe for the interrupt logic and the result latch, and a sticky `adcValid` flag. Integration waits until power has been held for a settling period. A halt request from the interrupt logic freezes integration. The freeze lasts until software drops ADC enable and raises it again.

Top module: `integ_cycle_ctrl`

## Requirements
- R1: Reset drives `integrating`, `cycleDone` and `adcValid` low and `manualTime` to zero.
- R2: `integrating` stays low unless `powerOn` and `adcEnable` are both high and `powerOn` has been high without a break for SETTLE_CYCLES clocks. Dropping either bit lowers `integrating` at the next clock.
- R3: In timed mode, with `timingVal` = T and T not 00h, `cycleDone` is high for one clock after every (256 − T)-th `intervalTick` counted from the start of integration. `integrating` stays high across the boundary, so the next cycle starts immediately.
- R4: `cycleDone` never lasts more than one clock. It is only raised when `integrating` was high on the previous clock.
- R5: `adcValid` is set together with the first `cycleDone`. It stays set while `powerOn` is high and clears at the clock after `powerOn` falls.
- R6: When `timingVal` is 00h, the block is in manual mode. `integrating` stays low until a `manualStart` pulse and rises one clock after it. A `manualStop` pulse lowers it at the next clock and produces one `cycleDone`.
- R7: `manualTime` clears on `manualStart`. It counts each `intervalTick` during manual integration and saturates at 255. It holds its value after stop.
- R8: Lowering `adcEnable` in the middle of a cycle ends integration without a `cycleDone`. Re-enabling restarts a full cycle of (256 − T) ticks.
- R9: A `haltReq` seen while integrating lowers `integrating` within two clocks. `integrating` then stays low, and ticks produce no `cycleDone`, until `adcEnable` is lowered and raised again.
- R10: An `intervalTick` outside integration has no effect on `cycleDone` or `manualTime`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerOn | input | 1 | Power bit from the control register |
| adcEnable | input | 1 | ADC enable bit from the control register |
| timingVal | input | CNT_W | Timing register value; 0 selects manual mode |
| intervalTick | input | 1 | One-clock pulse marking each 2.7 ms interval |
| manualStart | input | 1 | Manual-mode start command pulse |
| manualStop | input | 1 | Manual-mode stop command pulse |
| haltReq | input | 1 | Stop request from the interrupt logic |
| integrating | output | 1 | Integration active |
| cycleDone | output | 1 | One-clock end-of-cycle strobe |
| adcValid | output | 1 | Sticky flag: at least one cycle completed |
| manualTime | output | CNT_W | Manual-mode elapsed interval count |

## Verification
On every clock, the assertions check the following: the strobe is a single pulse that only follows integration, power or enable loss stops integration, the valid flag stays sticky under power and tracks the strobe, manual mode never starts without a start command, and the elapsed count holds at its saturation value. Other behaviour can only be shown by the bench's scenarios. This includes the exact tick count per cycle for several timing values, restarting from zero after an enable drop, the settling delay, and the halt freeze with its release sequence. It also includes whether ticks outside integration are ignored.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_TIMED    = 2'd1,
    ST_MAN_IDLE = 2'd2,
    ST_MAN_RUN  = 2'd3
  } iccState_e;

  typedef struct packed {
    logic loadCnt;
    logic stepCnt;
    logic clrElapsed;
    logic stepElapsed;
  } dpCtrl_t;
endpackage

// File: rtl/icc_settle.sv
module icc_settle #(
  parameter int SETTLE_CYCLES = 250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerOn,
  output logic settled
);
  localparam int W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [W-1:0] LIMIT = W'(SETTLE_CYCLES);

  logic [W-1:0] settleCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !powerOn) settleCnt <= '0;
    else if (settleCnt != LIMIT) settleCnt <= settleCnt + 1'b1;
  end

  assign settled = (settleCnt == LIMIT);
endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic [CNT_W-1:0] timingVal,
  output logic             cntAtMax,
  output logic [CNT_W-1:0] manualTime
);
  logic [CNT_W-1:0] intervalCnt;

  always_ff @(posedge clk) begin
    if (!rstN) intervalCnt <= '0;
    else if (dpCtrl.loadCnt) intervalCnt <= timingVal;
    else if (dpCtrl.stepCnt) intervalCnt <= intervalCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) manualTime <= '0;
    else if (dpCtrl.clrElapsed) manualTime <= '0;
    else if (dpCtrl.stepElapsed && !(&manualTime)) manualTime <= manualTime + 1'b1;
  end

  assign cntAtMax = &intervalCnt;
endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             powerOn,
  input  logic             adcEnable,
  input  logic             settled,
  input  logic [CNT_W-1:0] timingVal,
  input  logic             intervalTick,
  input  logic             manualStart,
  input  logic             manualStop,
  input  logic             haltReq,
  input  logic             cntAtMax,
  output dpCtrl_t          dpCtrl,
  output logic             integrating,
  output logic             cycleDone,
  output logic             adcValid
);
  iccState_e state, stateNxt;
  logic halted, runOk, doneNxt;

  assign runOk = powerOn && adcEnable && settled && !halted;
  assign integrating = (state == ST_TIMED) || (state == ST_MAN_RUN);

  always_comb begin
    stateNxt = state;
    dpCtrl   = '0;
    doneNxt  = 1'b0;
    if (!runOk) begin
      stateNxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (timingVal == '0) stateNxt = ST_MAN_IDLE;
          else begin
            stateNxt       = ST_TIMED;
            dpCtrl.loadCnt = 1'b1;
          end
        end
        ST_TIMED: begin
          if (intervalTick) begin
            if (cntAtMax) begin
              dpCtrl.loadCnt = 1'b1;
              doneNxt        = 1'b1;
            end else begin
              dpCtrl.stepCnt = 1'b1;
            end
          end
        end
        ST_MAN_IDLE: begin
          if (manualStart) begin
            stateNxt          = ST_MAN_RUN;
            dpCtrl.clrElapsed = 1'b1;
          end
        end
        ST_MAN_RUN: begin
          if (manualStop) begin
            stateNxt = ST_MAN_IDLE;
            doneNxt  = 1'b1;
          end else if (intervalTick) begin
            dpCtrl.stepElapsed = 1'b1;
          end
        end
        default: stateNxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_OFF;
      cycleDone <= 1'b0;
    end else begin
      state     <= stateNxt;
      cycleDone <= doneNxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !adcEnable) halted <= 1'b0;
    else if (haltReq && integrating) halted <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !powerOn) adcValid <= 1'b0;
    else if (doneNxt) adcValid <= 1'b1;
  end
endmodule

// File: rtl/integ_cycle_ctrl.sv
module integ_cycle_ctrl
  import icc_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int SETTLE_CYCLES = 250000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             powerOn,
  input  logic             adcEnable,
  input  logic [CNT_W-1:0] timingVal,
  input  logic             intervalTick,
  input  logic             manualStart,
  input  logic             manualStop,
  input  logic             haltReq,
  output logic             integrating,
  output logic             cycleDone,
  output logic             adcValid,
  output logic [CNT_W-1:0] manualTime
);
  dpCtrl_t dpCtrl;
  logic settled, cntAtMax;

  icc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) settle_i (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .settled(settled)
  );

  icc_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .adcEnable(adcEnable),
    .settled(settled), .timingVal(timingVal), .intervalTick(intervalTick),
    .manualStart(manualStart), .manualStop(manualStop), .haltReq(haltReq),
    .cntAtMax(cntAtMax), .dpCtrl(dpCtrl), .integrating(integrating),
    .cycleDone(cycleDone), .adcValid(adcValid)
  );

  icc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .timingVal(timingVal),
    .cntAtMax(cntAtMax), .manualTime(manualTime)
  );
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             powerOn,
  input logic             adcEnable,
  input logic [CNT_W-1:0] timingVal,
  input logic             manualStart,
  input logic             integrating,
  input logic             cycleDone,
  input logic             adcValid,
  input logic [CNT_W-1:0] manualTime
);
  assert_no_run_unpowered_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!powerOn || !adcEnable) |=> !integrating);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  assert_done_follows_integ_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cycleDone) |-> $past(integrating));

  assert_valid_with_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> adcValid);

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (adcValid && powerOn) |=> adcValid);

  assert_manual_needs_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (timingVal == '0 && !integrating && !manualStart) |=> !integrating);

  assert_elapsed_saturates_R7: assert property (@(posedge clk) disable iff (!rstN)
    (&manualTime) |=> ((&manualTime) || manualTime == '0));
endmodule

bind integ_cycle_ctrl icc_checker #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/integ_cycle_ctrl_tb_top.sv
module integ_cycle_ctrl_tb_top;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerOn = 1'b0, adcEnable = 1'b0;
  logic [7:0] timingVal = 8'h00;
  logic intervalTick = 1'b0, manualStart = 1'b0, manualStop = 1'b0, haltReq = 1'b0;
  logic integrating, cycleDone, adcValid;
  logic [7:0] manualTime;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  integ_cycle_ctrl #(.CNT_W(8), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .adcEnable(adcEnable),
    .timingVal(timingVal), .intervalTick(intervalTick), .manualStart(manualStart),
    .manualStop(manualStop), .haltReq(haltReq), .integrating(integrating),
    .cycleDone(cycleDone), .adcValid(adcValid), .manualTime(manualTime)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    intervalTick = 1'b1;
    @(negedge clk);
    intervalTick = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "integrating", int'(integrating), 0);
    check("R1", "cycleDone", int'(cycleDone), 0);
    check("R1", "adcValid", int'(adcValid), 0);
    check("R1", "manualTime", int'(manualTime), 0);
  endtask

  task automatic testSettle();
    timingVal = 8'hFE;
    powerOn = 1'b1;
    adcEnable = 1'b1;
    waitCycles(SETTLE / 2);
    check("R2", "integrating before settle", int'(integrating), 0);
    waitCycles(SETTLE);
    check("R2", "integrating after settle", int'(integrating), 1);
  endtask

  task automatic testTimed(logic [7:0] t, int nCycles);
    int ticksPer = 256 - int'(t);
    int doneSeen;
    adcEnable = 1'b0;
    waitCycles(2);
    timingVal = t;
    adcEnable = 1'b1;
    waitCycles(2);
    for (int c = 0; c < nCycles; c++) begin
      doneSeen = 0;
      for (int k = 1; k <= ticksPer; k++) begin
        tick();
        if (cycleDone) begin
          doneSeen++;
          if (k != ticksPer) check("R3", "early cycleDone at tick", k, ticksPer);
        end
      end
      check("R3", "cycleDone count per cycle", doneSeen, 1);
      check("R3", "integrating across boundary", int'(integrating), 1);
      check("R5", "adcValid after cycle", int'(adcValid), 1);
      waitCycles(1);
      check("R4", "cycleDone one clock", int'(cycleDone), 0);
    end
  endtask

  task automatic testAbort();
    int doneSeen = 0;
    adcEnable = 1'b0;
    waitCycles(2);
    timingVal = 8'hFD;
    adcEnable = 1'b1;
    waitCycles(2);
    tick();
    tick();
    adcEnable = 1'b0;
    waitCycles(1);
    check("R8", "integrating after enable drop", int'(integrating), 0);
    check("R8", "no cycleDone on abort", int'(cycleDone), 0);
    for (int k = 0; k < 4; k++) begin
      tick();
      if (cycleDone) doneSeen++;
    end
    check("R10", "idle ticks give no cycleDone", doneSeen, 0);
    adcEnable = 1'b1;
    waitCycles(2);
    tick();
    tick();
    check("R8", "restart: no done at tick 2", int'(cycleDone), 0);
    tick();
    check("R8", "restart: done at tick 3", int'(cycleDone), 1);
  endtask

  task automatic testManual();
    adcEnable = 1'b0;
    waitCycles(2);
    timingVal = 8'h00;
    adcEnable = 1'b1;
    waitCycles(3);
    check("R6", "idle before start", int'(integrating), 0);
    tick();
    check("R10", "manualTime unchanged by idle tick", int'(manualTime), 0);
    pulse(manualStart);
    check("R6", "integrating after start", int'(integrating), 1);
    check("R7", "manualTime cleared by start", int'(manualTime), 0);
    tick(); tick(); tick();
    check("R7", "manualTime after 3 ticks", int'(manualTime), 3);
    pulse(manualStop);
    check("R6", "cycleDone on stop", int'(cycleDone), 1);
    check("R6", "integrating after stop", int'(integrating), 0);
    tick();
    check("R7", "manualTime held after stop", int'(manualTime), 3);
    pulse(manualStart);
    check("R7", "manualTime cleared on restart", int'(manualTime), 0);
    for (int k = 0; k < 300; k++) tick();
    check("R7", "manualTime saturates", int'(manualTime), 255);
    pulse(manualStop);
    check("R7", "manualTime held at 255", int'(manualTime), 255);
  endtask

  task automatic testHalt();
    int doneSeen = 0;
    adcEnable = 1'b0;
    waitCycles(2);
    timingVal = 8'hFF;
    adcEnable = 1'b1;
    waitCycles(2);
    check("R9", "integrating before halt", int'(integrating), 1);
    pulse(haltReq);
    waitCycles(1);
    check("R9", "integrating after halt", int'(integrating), 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      if (cycleDone) doneSeen++;
    end
    check("R9", "no cycleDone while halted", doneSeen, 0);
    check("R9", "still halted", int'(integrating), 0);
    adcEnable = 1'b0;
    waitCycles(1);
    adcEnable = 1'b1;
    waitCycles(2);
    check("R9", "resumed after enable toggle", int'(integrating), 1);
  endtask

  task automatic testPowerOff();
    powerOn = 1'b0;
    waitCycles(1);
    check("R5", "adcValid cleared by power off", int'(adcValid), 0);
    check("R2", "integrating off without power", int'(integrating), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    waitCycles(1);
    testSettle();
    testTimed(8'hFE, 2);
    testTimed(8'hFF, 3);
    testTimed(8'hF0, 1);
    testTimed(8'h01, 1);
    testAbort();
    testManual();
    testHalt();
    testPowerOff();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule